// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM array alive. A free-running interval timer adds one owed refresh to a small pending counter each refresh interval. When refresh work is owed, the block raises a bus request towards the access sequencer and waits for the grant. It then drives the row and column strobes for one refresh cycle and lets the row strobe precharge. One clock after the precharge it drops the request. The refresh cycle is either column-before-row, where the DRAM's own row counter picks the row, or row-only, where the block presents the row from its own counter. A static mode input selects between the two.

After reset the block runs an initialization burst of eight refresh cycles in the selected style before it reports itself ready. On request it places the array in self refresh by holding both strobes low. The row strobe stays low for a minimum dwell, and after exit the row strobe gets a longer precharge. A catch-up burst of one refresh per row then runs before any other refresh work. Owed refreshes that cannot be served because the bus stays busy pile up to a limit, and a starvation flag marks that limit. All timings are parameters in clock cycles. The defaults suit a 125 MHz clock, a 4096-row array and a 64 ms retention window.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low, and after it, until work begins: ras_n, cas_n and we_n are high, bus_req is low, and pend_cnt, starve, init_done, self_active and catchup are all zero.
- R2: After reset the block completes exactly 8 refresh cycles before init_done rises; with row_mode=0 all of them are column-before-row cycles.
- R3: pend_cnt gains one every REF_INT clock cycles while not in self refresh, and each periodic refresh cycle removes one, so the steady-state refresh rate is one per REF_INT cycles.
- R4: In a column-before-row cycle cas_n falls exactly T_CSR cycles before ras_n, stays low for the whole ras_n low pulse, and ras_n is low for exactly T_RAS cycles; we_n is high at all times.
- R5: With row_mode=1 refresh cycles keep cas_n high while ras_n is low, and ref_addr advances by one, modulo 2^ROW_W, from one row-only cycle to the next.
- R6: No strobe falls while bus_gnt is low; bus_req is high whenever ras_n or cas_n is low.
- R7: bus_req falls T_RP+1 clock cycles after ras_n rises at the end of a refresh cycle, and SELF_EXIT+1 cycles after it rises at self refresh exit.
- R8: pend_cnt saturates at PEND_MAX (8 by default), and starve is high exactly while pend_cnt equals PEND_MAX.
- R9: A self refresh holds ras_n and cas_n low with self_active high for at least SELF_MIN cycles and for as long as self_req stays high; the interval timer is frozen and pend_cnt is cleared meanwhile.
- R10: After self refresh exit, catchup is high while 2^ROW_W refresh cycles run, and these run before any periodic refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_mode | input | 1 | 1 selects row-only refresh from the internal row counter, 0 selects column-before-row |
| self_req | input | 1 | Request to enter and stay in self refresh |
| bus_gnt | input | 1 | Strobe bus granted by the access sequencer |
| bus_req | output | 1 | Strobe bus requested |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| ref_addr | output | ROW_W | Row presented during row-only refresh |
| pend_cnt | output | $clog2(PEND_MAX+1) | Owed refresh cycles |
| starve | output | 1 | Pending limit reached |
| init_done | output | 1 | Initialization burst complete |
| self_active | output | 1 | Array held in self refresh |
| catchup | output | 1 | Post-self-refresh burst in progress |

## Verification
The assertions assume that the access sequencer, once it sees bus_req, holds bus_gnt steady until the request drops. They also assume that self_req is not withdrawn in the same cycle the grant is taken. The stimulus keeps bus_gnt at one constant level for each scenario. It changes row_mode only between scenarios, and it drops self_req only after self_active has been observed. Under these conditions every strobe edge can be traced to a granted cycle.

// File: rtl/dram_refresh_sched_pkg.sv
// Shared types for the refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package dram_refresh_sched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CASLEAD,
        ST_RAS,
        ST_SELF,
        ST_PRECH,
        ST_REL
    } seq_state_t;

    typedef enum logic [1:0] {
        JOB_INIT,
        JOB_CATCH,
        JOB_SELF,
        JOB_PERIODIC
    } job_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_refresh_interval.sv
// Interval timer and owed-refresh counter.
// Adds one owed refresh every REF_INT cycles, removes one on each served
// periodic cycle, saturates at PEND_MAX and clears on self refresh entry.
// Assumes: take is only pulsed while the count is non-zero.
module dram_refresh_interval #(
    parameter int REF_INT  = 1950,
    parameter int PEND_MAX = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pause,
    input  logic                          clear,
    input  logic                          take,
    output logic [$clog2(PEND_MAX+1)-1:0] pend,
    output logic                          starve
);
    localparam int IW = $clog2(REF_INT) > 0 ? $clog2(REF_INT) : 1;
    localparam int PW = $clog2(PEND_MAX + 1);

    logic [IW-1:0] ivl;
    logic          tick;
    logic          inc;

    assign tick   = !pause && (ivl == IW'(REF_INT - 1));
    assign inc    = tick && (pend != PW'(PEND_MAX));
    assign starve = (pend == PW'(PEND_MAX));

    // Free-running interval count, frozen during self refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)     ivl <= '0;
        else if (pause) ivl <= ivl;
        else if (tick)  ivl <= '0;
        else            ivl <= ivl + 1'b1;
    end

    // Owed refresh bookkeeping with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)             pend <= '0;
        else if (clear)         pend <= '0;
        else if (inc && !take)  pend <= pend + 1'b1;
        else if (!inc && take)  pend <= pend - 1'b1;
    end

    a_r8_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(PEND_MAX))
        else $error("R8 pending count above limit");

    a_r3_take_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend != '0)
        else $error("R3 periodic refresh served with nothing owed");

    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != $past(pend)) && !$past(clear) |->
            (pend == $past(pend) + 1'b1) || (pend + 1'b1 == $past(pend)))
        else $error("R3 pending count moved by more than one");

endmodule

// File: rtl/dram_refresh_seq.sv
// Refresh cycle sequencer.
// Picks the next job (init burst, catch-up burst, self refresh, periodic),
// requests the bus, drives the strobes phase by phase from one shared
// down-counter, and keeps the row counter for row-only refresh.
// Assumes: bus_gnt stays high once given until bus_req falls.
module dram_refresh_seq
    import dram_refresh_sched_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int INIT_CYC  = 8,
    parameter int T_CSR     = 1,
    parameter int T_RAS     = 7,
    parameter int T_RP      = 4,
    parameter int SELF_MIN  = 12500,
    parameter int SELF_EXIT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_mode,
    input  logic             self_req,
    input  logic             bus_gnt,
    input  logic             pend_nz,
    output logic             bus_req,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] ref_addr,
    output logic             init_done,
    output logic             self_active,
    output logic             catchup,
    output logic             pause,
    output logic             clear,
    output logic             take
);
    localparam int ROWS    = 1 << ROW_W;
    localparam int BURST_W = $clog2(umax(ROWS, INIT_CYC) + 1);
    localparam int TMAX    = umax(umax(T_CSR, T_RAS), umax(umax(T_RP, SELF_EXIT), SELF_MIN));
    localparam int TW      = $clog2(TMAX + 1);

    seq_state_t         state;
    job_t               job, nxt_job;
    logic               use_row;
    logic               has_work;
    logic               phase_end;
    logic [TW-1:0]      tcnt;
    logic [BURST_W-1:0] burst_left;
    logic               init_q, catch_q;
    logic [ROW_W-1:0]   row_ctr;
    logic               done;

    assign phase_end = (tcnt == '0);
    assign done      = (state == ST_PRECH) && phase_end;

    // Job priority: init, then catch-up, then self refresh, then periodic.
    always_comb begin
        has_work = 1'b1;
        if (!init_q)        nxt_job = JOB_INIT;
        else if (catch_q)   nxt_job = JOB_CATCH;
        else if (self_req)  nxt_job = JOB_SELF;
        else if (pend_nz)   nxt_job = JOB_PERIODIC;
        else begin
            nxt_job  = JOB_PERIODIC;
            has_work = 1'b0;
        end
    end

    // Phase sequencing with a single shared phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            job     <= JOB_INIT;
            use_row <= 1'b0;
            tcnt    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (has_work) begin
                    state   <= ST_WAIT;
                    job     <= nxt_job;
                    use_row <= row_mode;
                end
                ST_WAIT: if (bus_gnt) begin
                    if (job != JOB_SELF && use_row) begin
                        state <= ST_RAS;
                        tcnt  <= TW'(T_RAS - 1);
                    end else begin
                        state <= ST_CASLEAD;
                        tcnt  <= TW'(T_CSR - 1);
                    end
                end
                ST_CASLEAD: if (!phase_end) tcnt <= tcnt - 1'b1;
                    else if (job == JOB_SELF) begin
                        state <= ST_SELF;
                        tcnt  <= TW'(SELF_MIN - 1);
                    end else begin
                        state <= ST_RAS;
                        tcnt  <= TW'(T_RAS - 1);
                    end
                ST_RAS: if (!phase_end) tcnt <= tcnt - 1'b1;
                    else begin
                        state <= ST_PRECH;
                        tcnt  <= TW'(T_RP - 1);
                    end
                ST_SELF: if (!phase_end) tcnt <= tcnt - 1'b1;
                    else if (!self_req) begin
                        state <= ST_PRECH;
                        tcnt  <= TW'(SELF_EXIT - 1);
                    end
                ST_PRECH: if (!phase_end) tcnt <= tcnt - 1'b1;
                    else state <= ST_REL;
                ST_REL:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Burst, readiness and row counter bookkeeping at cycle completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_left <= BURST_W'(INIT_CYC);
            init_q     <= 1'b0;
            catch_q    <= 1'b0;
            row_ctr    <= '0;
        end else if (done) begin
            if (job != JOB_SELF && use_row) row_ctr <= row_ctr + 1'b1;
            case (job)
                JOB_INIT: begin
                    burst_left <= burst_left - 1'b1;
                    if (burst_left == BURST_W'(1)) init_q <= 1'b1;
                end
                JOB_CATCH: begin
                    burst_left <= burst_left - 1'b1;
                    if (burst_left == BURST_W'(1)) catch_q <= 1'b0;
                end
                JOB_SELF: begin
                    burst_left <= BURST_W'(ROWS);
                    catch_q    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Strobe and status decode from the registered phase.
    always_comb begin
        ras_n       = !(state == ST_RAS || state == ST_SELF);
        cas_n       = !(state == ST_CASLEAD || state == ST_SELF || (state == ST_RAS && !use_row));
        we_n        = 1'b1;
        bus_req     = (state != ST_IDLE);
        self_active = (state == ST_SELF);
        pause       = (job == JOB_SELF) && (state != ST_IDLE);
        clear       = (state == ST_WAIT) && bus_gnt && (job == JOB_SELF);
        take        = done && (job == JOB_PERIODIC);
    end

    assign ref_addr  = row_ctr;
    assign init_done = init_q;
    assign catchup   = catch_q;

    a_r6_grant_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WAIT && state != ST_WAIT) |-> $past(bus_gnt))
        else $error("R6 cycle started without grant");

    a_r4_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> ras_n)
        else $error("R4 column strobe released while row strobe low");

    a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_addr != $past(ref_addr)) |-> ref_addr == ROW_W'($past(ref_addr) + 1'b1))
        else $error("R5 row counter skipped");

    a_r9_self_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (self_active && self_req) |=> (!ras_n && !cas_n))
        else $error("R9 self refresh left while still requested");

    a_r7_release_after_prech: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> ras_n && $past(ras_n) && $past(cas_n))
        else $error("R7 request dropped without precharge");

    a_r10_catch_first: assert property (@(posedge clk) disable iff (!rst_n)
        (catchup && state == ST_WAIT) |-> job == JOB_CATCH)
        else $error("R10 other job ran during catch-up");

    a_r2_init_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> job == JOB_INIT)
        else $error("R2 ready raised outside init burst");

endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM refresh scheduler top.
// Joins the interval timer with the refresh cycle sequencer.
// Assumes: one clock domain, synchronous active-low reset.
module dram_refresh_sched #(
    parameter int ROW_W     = 12,
    parameter int REF_INT   = 1950,
    parameter int PEND_MAX  = 8,
    parameter int INIT_CYC  = 8,
    parameter int T_CSR     = 1,
    parameter int T_RAS     = 7,
    parameter int T_RP      = 4,
    parameter int SELF_MIN  = 12500,
    parameter int SELF_EXIT = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          row_mode,
    input  logic                          self_req,
    input  logic                          bus_gnt,
    output logic                          bus_req,
    output logic                          ras_n,
    output logic                          cas_n,
    output logic                          we_n,
    output logic [ROW_W-1:0]              ref_addr,
    output logic [$clog2(PEND_MAX+1)-1:0] pend_cnt,
    output logic                          starve,
    output logic                          init_done,
    output logic                          self_active,
    output logic                          catchup
);
    logic pause, clear, take, pend_nz;

    assign pend_nz = (pend_cnt != '0);

    dram_refresh_interval #(
        .REF_INT  (REF_INT),
        .PEND_MAX (PEND_MAX)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .pause  (pause),
        .clear  (clear),
        .take   (take),
        .pend   (pend_cnt),
        .starve (starve)
    );

    dram_refresh_seq #(
        .ROW_W     (ROW_W),
        .INIT_CYC  (INIT_CYC),
        .T_CSR     (T_CSR),
        .T_RAS     (T_RAS),
        .T_RP      (T_RP),
        .SELF_MIN  (SELF_MIN),
        .SELF_EXIT (SELF_EXIT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_mode    (row_mode),
        .self_req    (self_req),
        .bus_gnt     (bus_gnt),
        .pend_nz     (pend_nz),
        .bus_req     (bus_req),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .ref_addr    (ref_addr),
        .init_done   (init_done),
        .self_active (self_active),
        .catchup     (catchup),
        .pause       (pause),
        .clear       (clear),
        .take        (take)
    );

    a_r6_strobe_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> bus_req)
        else $error("R6 strobe active without request");

endmodule

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
    localparam int ROW_W     = 3;
    localparam int ROWS      = 1 << ROW_W;
    localparam int REF_INT   = 40;
    localparam int PEND_MAX  = 8;
    localparam int T_CSR     = 1;
    localparam int T_RAS     = 7;
    localparam int T_RP      = 4;
    localparam int SELF_MIN  = 30;
    localparam int SELF_EXIT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_mode = 1'b0;
    logic self_req = 1'b0;
    logic bus_gnt = 1'b0;
    logic bus_req, ras_n, cas_n, we_n, starve, init_done, self_active, catchup;
    logic [ROW_W-1:0] ref_addr;
    logic [$clog2(PEND_MAX+1)-1:0] pend_cnt;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .ROW_W(ROW_W), .REF_INT(REF_INT), .PEND_MAX(PEND_MAX), .T_CSR(T_CSR),
        .T_RAS(T_RAS), .T_RP(T_RP), .SELF_MIN(SELF_MIN), .SELF_EXIT(SELF_EXIT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .row_mode(row_mode), .self_req(self_req),
        .bus_gnt(bus_gnt), .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ref_addr(ref_addr), .pend_cnt(pend_cnt), .starve(starve),
        .init_done(init_done), .self_active(self_active), .catchup(catchup)
    );

    // Strobe monitor, sampled on the falling edge.
    int n_fall, n_cbr, n_row, bad_lead, bad_width, bad_hold, bad_rel, bad_addr, bad_req, bad_we;
    int cas_run = 0, ras_run = 0, since_rise = 0, exp_rel = T_RP + 1, self_len = 0;
    bit prev_ras = 1, prev_cas = 1, prev_req = 0, self_seen = 0, have_addr = 0;
    logic [ROW_W-1:0] last_addr;

    task automatic zero_mon();
        n_fall = 0; n_cbr = 0; n_row = 0; bad_lead = 0; bad_width = 0; bad_hold = 0;
        bad_rel = 0; bad_addr = 0; bad_req = 0; bad_we = 0; have_addr = 0;
    endtask

    always @(negedge clk) begin
        if (we_n !== 1'b1) bad_we++;
        if ((!ras_n || !cas_n) && !bus_req) bad_req++;
        if (!prev_cas && cas_n && !ras_n) bad_hold++;
        if (prev_ras && !ras_n) begin
            n_fall++;
            ras_run = 1;
            if (!cas_n) begin
                n_cbr++;
                if (cas_run != T_CSR && !self_active) bad_lead++;
            end else begin
                n_row++;
                if (have_addr && ref_addr != ROW_W'(last_addr + 1'b1)) bad_addr++;
                last_addr = ref_addr;
                have_addr = 1;
            end
        end else if (!ras_n) ras_run++;
        if (self_active) self_seen = 1;
        if (!prev_ras && ras_n) begin
            if (self_seen) begin
                self_len = ras_run;
                exp_rel = SELF_EXIT + 1;
            end else begin
                if (ras_run != T_RAS) bad_width++;
                exp_rel = T_RP + 1;
            end
            self_seen = 0;
            since_rise = 0;
        end else since_rise++;
        if (prev_req && !bus_req && since_rise != exp_rel) bad_rel++;
        if (!cas_n) cas_run++; else cas_run = 0;
        prev_ras = ras_n; prev_cas = cas_n; prev_req = bus_req;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    // R1: quiet outputs in and right after reset.
    task automatic t_reset();
        rst_n = 0; bus_gnt = 0;
        step(5);
        check("R1 strobes", {ras_n, cas_n, we_n}, 3'b111);
        check("R1 request", bus_req, 0);
        check("R1 status", {pend_cnt, starve, init_done, self_active, catchup}, 0);
        zero_mon();
        rst_n = 1;
    endtask

    // R8, R6: grant held low, owed count saturates, no strobe activity.
    task automatic t_starve();
        step(7 * REF_INT + 20);
        check("R8 pend before limit", pend_cnt, 7);
        check("R8 starve before limit", starve, 0);
        step(2 * REF_INT);
        check("R8 pend saturated", pend_cnt, PEND_MAX);
        check("R8 starve at limit", starve, 1);
        check("R6 no strobe without grant", n_fall, 0);
        check("R6 request waiting", bus_req, 1);
    endtask

    // R2, R4, R7: initialization burst then drain.
    task automatic t_init();
        bus_gnt = 1;
        for (int i = 0; i < 1000 && !init_done; i++) step(1);
        check("R2 init done", init_done, 1);
        check("R2 init cbr cycles", n_cbr, 8);
        check("R2 init row-only cycles", n_row, 0);
        for (int i = 0; i < 3000 && (pend_cnt != 0 || bus_req); i++) step(1);
        check("R8 starve cleared", starve, 0);
        check("R4 cas lead", bad_lead, 0);
        check("R4 ras width", bad_width, 0);
        check("R4 cas hold", bad_hold, 0);
        check("R7 release timing", bad_rel, 0);
    endtask

    // R3: steady periodic rate in column-before-row style.
    task automatic t_periodic();
        zero_mon();
        step(10 * REF_INT);
        check_range("R3 periodic count", n_cbr, 9, 11);
        check("R3 no row-only", n_row, 0);
        check("R4 cas lead periodic", bad_lead, 0);
        check("R7 release periodic", bad_rel, 0);
    endtask

    // R5: row-only style with stepping address.
    task automatic t_row();
        row_mode = 1;
        zero_mon();
        step(10 * REF_INT);
        check_range("R5 row-only count", n_row, 9, 11);
        check("R5 address step", bad_addr, 0);
        check("R5 cas high", n_cbr, 0);
        check("R4 ras width row", bad_width, 0);
        for (int i = 0; i < 100 && bus_req; i++) step(1);
        row_mode = 0;
    endtask

    // R9, R10, R7: short self refresh then catch-up burst.
    task automatic t_self_short();
        zero_mon();
        self_req = 1;
        for (int i = 0; i < 200 && !self_active; i++) step(1);
        check("R9 self entered", self_active, 1);
        check("R9 both strobes low", {ras_n, cas_n}, 0);
        self_req = 0;
        for (int i = 0; i < 200 && !catchup; i++) step(1);
        check("R9 minimum dwell", self_len, SELF_MIN);
        check("R10 catch-up raised", catchup, 1);
        n_cbr = 0; n_row = 0;
        for (int i = 0; i < 1000 && catchup; i++) step(1);
        check("R10 catch-up count", n_cbr, ROWS);
        check("R7 self exit release", bad_rel, 0);
    endtask

    // R9: long self refresh freezes the timer.
    task automatic t_self_long();
        for (int i = 0; i < 500 && (pend_cnt != 0 || bus_req); i++) step(1);
        zero_mon();
        self_req = 1;
        for (int i = 0; i < 200 && !self_active; i++) step(1);
        step(3 * SELF_MIN);
        check("R9 still in self", {self_active, ras_n, cas_n}, 3'b100);
        check("R9 timer frozen", pend_cnt, 0);
        self_req = 0;
        for (int i = 0; i < 1000 && !catchup; i++) step(1);
        check_range("R9 long dwell", self_len, 3 * SELF_MIN, 3 * SELF_MIN + 2);
        for (int i = 0; i < 1000 && catchup; i++) step(1);
        check("R6 strobe only with request", bad_req, 0);
        check("R4 we high", bad_we, 0);
    endtask

    initial begin
        zero_mon();
        t_reset();
        t_starve();
        t_init();
        t_periodic();
        t_row();
        t_self_short();
        t_self_long();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule